// File: doc/BRIEF.md
# Serial MII PHY-side Framer

This block sits at one port of a multi-port physical-layer device. It turns the serial link to the MAC into parallel MII-style signals and builds the serial stream in the other direction. A single 125 MHz reference clock times both directions. A one-clock `sync` pulse marks the first bit of each 10-bit segment. In the transmit direction the framer collects each segment and presents its error flag, enable flag and data byte in parallel, with a one-cycle strobe. In the receive direction it takes carrier, data-valid and the data byte from the port logic and sends them out one bit per clock. Between frames it sends a port status byte in place of data.

At 10 Mbps every segment is sent ten times in a row. The receive serialiser loads fresh content once per group of ten. The transmit deserialiser decodes only the first copy of each group. The rate can change between packets, but only at a group boundary while neither direction is inside a frame. A test loopback, honoured only at 100 Mbps, builds the receive segments from the transmit segments just decoded.

Top module: `smii_phy_framer`

## Requirements
- R1: After reset `rxSer`, `txEr`, `txEn`, `txValid` and `txData` are all 0, and `rxSer` stays 0 until the first `sync` pulse is seen.
- R2: The edge at which `sync` is high samples segment bit 0, and the following nine edges sample bits 1 to 9. If `sync` is missing, the bit position keeps counting modulo 10. A `sync` pulse in the middle of a segment restarts the count at bit 0.
- R3: The transmit segment carries bit 0 = error flag, bit 1 = enable flag, and bits 2..9 = data byte with the LSB first. `txEr`, `txEn` and `txData` update at the edge that samples bit 9. `txValid` is high for exactly the one following cycle.
- R4: While `rxDv` is 1, the receive segment carries bit 0 = `rxCrs`, bit 1 = `rxDv`, and bits 2..9 = `rxData` with the LSB first. The inputs are sampled at the segment's start edge. After that start edge, bit k of the segment is on `rxSer` following the k-th edge.
- R5: While `rxDv` is 0, bits 2..9 carry a status byte instead of data. Its bit 0 is the active rate (1 = 100 Mbps), bit 1 is `fullDuplex`, bit 2 is 0, bit 3 is `linkUp`, bit 4 is `jabber`, and bits 5 to 7 are 1.
- R6: At 10 Mbps only the first copy of each group of ten transmit segments is decoded, so `txValid` pulses once per group.
- R7: At 10 Mbps the receive inputs are sampled only at the start of a group, and all ten copies in the group carry the same segment. Input changes during copies 2 to 10 have no effect.
- R8: A new value of `speed100` takes effect only at a group boundary. It is taken only when `rxDv` is 0 and the last decoded `txEn` is 0. At 100 Mbps every segment is a group boundary. Otherwise the previous rate is kept.
- R9: With `loopEn` set at 100 Mbps, each fresh receive segment is built as carrier = enable = last decoded `txEn`. Its data field is the last decoded `txData` when that enable is 1, and the status byte when it is 0. At 10 Mbps `loopEn` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Segment start pulse |
| txSer | input | 1 | Serial transmit stream from the MAC |
| txEr | output | 1 | Decoded transmit error flag |
| txEn | output | 1 | Decoded transmit enable |
| txData | output | 8 | Decoded transmit data byte |
| txValid | output | 1 | One-cycle strobe for a newly decoded segment |
| rxCrs | input | 1 | Carrier sense from the port |
| rxDv | input | 1 | Receive data valid from the port |
| rxData | input | 8 | Receive data byte from the port |
| linkUp | input | 1 | Link status for the status byte |
| jabber | input | 1 | Jabber status for the status byte |
| fullDuplex | input | 1 | Duplex status for the status byte |
| speed100 | input | 1 | Requested rate, 1 = 100 Mbps |
| loopEn | input | 1 | Loopback request |
| rxSer | output | 1 | Serial receive stream to the MAC |

## Verification
Each transmit result is due at the edge that samples the segment's tenth bit. `txValid` is high during the single cycle after that edge. Bit k of a receive segment appears on `rxSer` after the k-th edge following the segment's start edge, so a whole segment has been delivered once the edge with index 9 has passed. The driver records the bit index of every edge at the preceding falling edge. The monitor samples one nanosecond after each rising edge and compares a receive segment only when that edge's index is 9. It pops the transmit scoreboard only on `txValid`, so a missing decode or an extra decode of a repeated copy is reported.

// File: rtl/smii_framer_pkg.sv
package smii_framer_pkg;

  // Per-edge strobes from the segment control to the datapath.
  typedef struct packed {
    logic active;    // alignment known (or sync present this edge)
    logic fresh;     // load new receive content at this start edge
    logic sampleTx;  // this edge samples bit 9 of a transmit copy to decode
    logic spd100;    // active rate as of this edge
    logic loop;      // loopback in effect for a fresh load
  } segStrb_t;

  localparam logic [2:0] STATUS_FILL = 3'b111;

endpackage

// File: rtl/smii_seg_ctrl.sv
module smii_seg_ctrl
  import smii_framer_pkg::*;
#(
  parameter  int SEG_BITS = 10,
  parameter  int REPEAT   = 10,
  localparam int IDX_W    = $clog2(SEG_BITS),
  localparam int REP_W    = $clog2(REPEAT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sync,
  input  logic             speed100,
  input  logic             loopEn,
  input  logic             rxDvIn,
  input  logic             txEnHeld,
  output logic [IDX_W-1:0] bitIdx,
  output segStrb_t         strb
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEG_BITS - 1);
  localparam logic [REP_W-1:0] LAST_REP = REP_W'(REPEAT - 1);

  logic [IDX_W-1:0] pos;
  logic [IDX_W-1:0] curIdx;
  logic [REP_W-1:0] segIdx;
  logic             aligned;
  logic             spdEff;
  logic             spdNew;
  logic             active;
  logic             segStart;
  logic             boundary;
  logic             idle;

  always_comb begin
    if (sync)                curIdx = '0;
    else if (pos == LAST_IDX) curIdx = '0;
    else                     curIdx = pos + IDX_W'(1);
    active   = sync | aligned;
    segStart = active && (curIdx == '0);
    boundary = spdEff || (segIdx == LAST_REP);
    idle     = !rxDvIn && !txEnHeld;
    spdNew   = (segStart && boundary && idle) ? speed100 : spdEff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos     <= LAST_IDX;
      aligned <= 1'b0;
      segIdx  <= '0;
      spdEff  <= 1'b1;
    end else begin
      pos <= curIdx;
      if (sync) aligned <= 1'b1;
      if (segStart) begin
        spdEff <= spdNew;
        segIdx <= boundary ? '0 : segIdx + REP_W'(1);
      end
    end
  end

  always_comb begin
    bitIdx        = curIdx;
    strb.active   = active;
    strb.fresh    = segStart && boundary;
    strb.sampleTx = active && (curIdx == LAST_IDX) && (segIdx == '0);
    strb.spd100   = spdNew;
    strb.loop     = loopEn && spdNew;
  end

  // R2: a sync pulse always restarts the bit position at zero
  a_r2_sync_aligns: assert property (@(posedge clk) disable iff (!rstN)
    sync |=> (pos == '0));

  // R8: the active rate cannot move except at a group boundary
  a_r8_speed_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(segStart && boundary) |=> $stable(spdEff));

  // R6: decode strobes never come on consecutive edges
  a_r6_one_sample: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleTx |=> !strb.sampleTx);

endmodule

// File: rtl/smii_seg_datapath.sv
module smii_seg_datapath
  import smii_framer_pkg::*;
#(
  parameter  int DATA_W   = 8,
  localparam int SEG_BITS = DATA_W + 2,
  localparam int IDX_W    = $clog2(SEG_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrb_t          strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              txSer,
  input  logic              rxCrs,
  input  logic              rxDv,
  input  logic [DATA_W-1:0] rxData,
  input  logic              linkUp,
  input  logic              jabber,
  input  logic              fullDuplex,
  output logic              txEr,
  output logic              txEn,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  output logic              rxSer
);

  logic [SEG_BITS-1:0] txShift;
  logic [SEG_BITS-1:0] rxSeg;
  logic [SEG_BITS-1:0] freshSeg;
  logic [SEG_BITS-1:0] segSel;
  logic [DATA_W-1:0]   statusByte;
  logic                txErQ, txEnQ, txValidQ, rxSerQ;
  logic [DATA_W-1:0]   txDataQ;

  // Status byte sent in place of data between frames.
  always_comb begin
    statusByte      = '0;
    statusByte[0]   = strb.spd100;
    statusByte[1]   = fullDuplex;
    statusByte[2]   = 1'b0;
    statusByte[3]   = linkUp;
    statusByte[4]   = jabber;
    statusByte[7:5] = STATUS_FILL;
  end

  // Transmit: collect bits by position, decode when bit 9 arrives.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      txErQ    <= 1'b0;
      txEnQ    <= 1'b0;
      txDataQ  <= '0;
      txValidQ <= 1'b0;
    end else begin
      if (strb.active) txShift[bitIdx] <= txSer;
      txValidQ <= strb.sampleTx;
      if (strb.sampleTx) begin
        txErQ   <= txShift[0];
        txEnQ   <= txShift[1];
        txDataQ <= {txSer, txShift[SEG_BITS-2:2]};
      end
    end
  end

  // Receive: build a fresh segment, or repeat the held one.
  always_comb begin
    if (strb.loop) begin
      freshSeg[0]            = txEnQ;
      freshSeg[1]            = txEnQ;
      freshSeg[SEG_BITS-1:2] = txEnQ ? txDataQ : statusByte;
    end else begin
      freshSeg[0]            = rxCrs;
      freshSeg[1]            = rxDv;
      freshSeg[SEG_BITS-1:2] = rxDv ? rxData : statusByte;
    end
    segSel = strb.fresh ? freshSeg : rxSeg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSeg  <= '0;
      rxSerQ <= 1'b0;
    end else begin
      if (strb.fresh) rxSeg <= freshSeg;
      rxSerQ <= strb.active ? segSel[bitIdx] : 1'b0;
    end
  end

  assign txEr    = txErQ;
  assign txEn    = txEnQ;
  assign txData  = txDataQ;
  assign txValid = txValidQ;
  assign rxSer   = rxSerQ;

  // R3: each decode strobe lasts exactly one cycle
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> !txValid);

  // R4: first bit of a freshly loaded, non-looped segment is the carrier input
  a_r4_first_bit_crs: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fresh && !strb.loop) |=> (rxSer == $past(rxCrs)));

endmodule

// File: rtl/smii_phy_framer.sv
module smii_phy_framer
  import smii_framer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REPEAT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sync,
  input  logic              txSer,
  output logic              txEr,
  output logic              txEn,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              rxCrs,
  input  logic              rxDv,
  input  logic [DATA_W-1:0] rxData,
  input  logic              linkUp,
  input  logic              jabber,
  input  logic              fullDuplex,
  input  logic              speed100,
  input  logic              loopEn,
  output logic              rxSer
);

  localparam int SEG_BITS = DATA_W + 2;
  localparam int IDX_W    = $clog2(SEG_BITS);

  segStrb_t         strb;
  logic [IDX_W-1:0] bitIdx;
  logic             txEnInt;

  smii_seg_ctrl #(.SEG_BITS(SEG_BITS), .REPEAT(REPEAT)) i_ctrl (
    .clk(clk), .rstN(rstN), .sync(sync), .speed100(speed100),
    .loopEn(loopEn), .rxDvIn(rxDv), .txEnHeld(txEnInt),
    .bitIdx(bitIdx), .strb(strb)
  );

  smii_seg_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx),
    .txSer(txSer), .rxCrs(rxCrs), .rxDv(rxDv), .rxData(rxData),
    .linkUp(linkUp), .jabber(jabber), .fullDuplex(fullDuplex),
    .txEr(txEr), .txEn(txEnInt), .txData(txData), .txValid(txValid),
    .rxSer(rxSer)
  );

  assign txEn = txEnInt;

endmodule

// File: tb/test_smii_phy_framer.sv
module test_smii_phy_framer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sync = 1'b0, txSer = 1'b0;
  logic rxCrs = 1'b0, rxDv = 1'b0;
  logic [7:0] rxData = '0;
  logic linkUp = 1'b1, jabber = 1'b0, fullDuplex = 1'b1;
  logic speed100 = 1'b1, loopEn = 1'b0;
  logic txEr, txEn, txValid, rxSer;
  logic [7:0] txData;

  int errors = 0, checks = 0;
  int benchIdx = -1;
  bit done = 0;
  logic [9:0] rxCap;
  logic [10:0] rxQ[$];
  string rxTagQ[$];
  logic [9:0] txQ[$];
  string txTagQ[$];

  always #4 clk = ~clk;

  smii_phy_framer i_smii_phy_framer (
    .clk(clk), .rstN(rstN), .sync(sync), .txSer(txSer),
    .txEr(txEr), .txEn(txEn), .txData(txData), .txValid(txValid),
    .rxCrs(rxCrs), .rxDv(rxDv), .rxData(rxData), .linkUp(linkUp),
    .jabber(jabber), .fullDuplex(fullDuplex), .speed100(speed100),
    .loopEn(loopEn), .rxSer(rxSer)
  );

  task automatic chk(input string tag, input string what,
                     input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic spd);
    return {3'b111, jabber, linkUp, 1'b0, fullDuplex, spd};
  endfunction

  function automatic logic [9:0] seg(input logic crs, input logic dv, input logic [7:0] d);
    return {d, dv, crs};
  endfunction

  // Driver: one 10-bit segment, pushing expectations into the scoreboard.
  task automatic runSeg(input logic [9:0] txBits, input logic doSync,
                        input logic chkRx, input logic [9:0] rxExp, input string rxTag,
                        input logic chkTx, input string txTag);
    rxQ.push_back({chkRx, rxExp});
    rxTagQ.push_back(rxTag);
    if (chkTx) begin
      txQ.push_back(txBits);
      txTagQ.push_back(txTag);
    end
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      sync = doSync && (k == 0);
      txSer = txBits[k];
      benchIdx = k;
    end
  endtask

  task automatic partial(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sync = 1'b0;
      txSer = 1'b1;
      benchIdx = -1;
    end
  endtask

  // Monitor: sample one ns after each rising edge.
  always @(posedge clk) begin
    logic [10:0] ent;
    string tg;
    logic [9:0] te;
    #1;
    if (!done) begin
      if (benchIdx >= 0) rxCap[benchIdx] = rxSer;
      if (benchIdx == 9 && rxQ.size() > 0) begin
        ent = rxQ.pop_front();
        tg = rxTagQ.pop_front();
        if (ent[10]) chk(tg, "rx segment", rxCap, ent[9:0]);
      end
      if (txValid) begin
        if (txQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 unexpected txValid: actual 1 expected 0");
        end else begin
          te = txQ.pop_front();
          tg = txTagQ.pop_front();
          chk(tg, "tx decode", {txData, txEn, txEr}, te);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [9:0] e;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state, no sync seen yet
    chk("R1", "outputs after reset", {txData, txEn, txEr}, 10'h0);
    chk("R1", "rxSer/txValid idle", {8'h0, rxSer, txValid}, 10'h0);

    // 100 Mbps frames: R3 and R4
    rxCrs = 1; rxDv = 1; rxData = 8'hA5;
    runSeg({8'h3C, 1'b1, 1'b0}, 1, 1, seg(1, 1, 8'hA5), "R4", 1, "R3");
    rxData = 8'h5A;
    runSeg({8'hC3, 1'b1, 1'b1}, 1, 1, seg(1, 1, 8'h5A), "R4", 1, "R3");
    // R5 inter-frame status
    rxCrs = 0; rxDv = 0; rxData = 8'h99; jabber = 1;
    runSeg(10'h0, 1, 1, seg(0, 0, stat(1)), "R5", 1, "R3");
    jabber = 0; linkUp = 0;
    runSeg(10'h0, 1, 1, seg(0, 0, stat(1)), "R5", 1, "R3");
    linkUp = 1;
    // R2 missing sync keeps alignment
    rxCrs = 1; rxDv = 1; rxData = 8'h0F;
    runSeg({8'h81, 1'b1, 1'b0}, 0, 1, seg(1, 1, 8'h0F), "R2", 1, "R2");
    // R2 realign after a stray partial segment
    partial(4);
    rxCrs = 0; rxDv = 0;
    runSeg(10'h0, 1, 1, seg(0, 0, stat(1)), "R2", 1, "R2");

    // Switch to 10 Mbps while idle: R6, R7, R8
    speed100 = 0;
    e = seg(0, 0, stat(0));
    runSeg({8'h96, 1'b1, 1'b0}, 1, 1, e, "R8", 1, "R6");
    for (int c = 1; c < 10; c++) begin
      rxCrs = 1; rxDv = 1; rxData = 8'(c * 37 + 5);
      runSeg({8'(c * 11), 1'b0, 1'b1}, 1, 1, e, "R7", 0, "");
    end
    // R8: request 100 Mbps while last txEn is 1 -> stays 10 Mbps
    speed100 = 1; rxCrs = 0; rxDv = 0;
    e = seg(0, 0, stat(0));
    runSeg(10'h0, 1, 1, e, "R8", 1, "R6");
    for (int c = 1; c < 10; c++) begin
      rxCrs = 1; rxDv = 1; rxData = 8'(c * 29 + 3);
      runSeg({8'(c * 7), 1'b1, 1'b0}, 1, 1, e, "R7", 0, "");
    end
    // Now idle at a group boundary -> 100 Mbps, per-segment loading
    rxCrs = 0; rxDv = 0;
    runSeg(10'h0, 1, 1, seg(0, 0, stat(1)), "R8", 1, "R8");
    rxCrs = 1; rxDv = 1; rxData = 8'h3E;
    runSeg(10'h0, 1, 1, seg(1, 1, 8'h3E), "R8", 1, "R8");

    // R9 loopback at 100 Mbps; port receive inputs are ignored
    loopEn = 1; rxCrs = 1; rxDv = 1; rxData = 8'hFF;
    runSeg({8'h5D, 1'b1, 1'b0}, 1, 1, seg(0, 0, stat(1)), "R9", 1, "R3");
    runSeg({8'hE2, 1'b1, 1'b0}, 1, 1, seg(1, 1, 8'h5D), "R9", 1, "R3");
    runSeg(10'h0, 1, 1, seg(1, 1, 8'hE2), "R9", 1, "R3");
    rxDv = 0;
    runSeg(10'h0, 1, 1, seg(0, 0, stat(1)), "R9", 1, "R3");
    // R9 loopback ignored once the rate drops to 10 Mbps
    speed100 = 0; rxCrs = 1; rxDv = 0;
    e = seg(1, 0, stat(0));
    runSeg(10'h0, 1, 1, e, "R9", 1, "R6");
    for (int c = 1; c < 10; c++) runSeg(10'h0, 1, 1, e, "R7", 0, "");

    repeat (3) @(negedge clk);
    benchIdx = -1;
    repeat (3) @(negedge clk);
    chk("R6", "pending tx decodes", 10'(txQ.size()), 10'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule